// File: doc/BRIEF.md
# Arbitration Acceleration Enable Controller

This block decides, cycle by cycle, whether the physical layer's arbitration speed-ups may be used. The speed-ups are fly-by concatenation of isochronous packets, concatenation of fair and priority packets onto acknowledges, and faster fair and priority arbitration after an acknowledge. A configuration master bit must be set before any of them can run. On top of that bit sits a temporary disable flag. The link drives this flag with single-cycle acceleration-control strobes. A bus reset or an isochronous bus request clears the flag, which restores the speed-ups.

The block also holds the link-side policy unit. When the link's cycle counter rolls over, a cycle start message is about to arrive. The policy asks for the speed-ups to be switched off at that point, and asks for them to be switched back on when a cycle start is received. The policy remembers the last state it requested and never repeats it. Each policy request leaves the block on its own pins and is also applied to the flag inside the block.

Requests are serviced at once, so there is no back-pressure. Every strobe is a one-cycle pulse with no ready signal, and all pins are plain control signals.

Top module: `accel_enable_ctrl`

## Requirements
- R1: After reset the disable flag is clear, so `accel_en` equals `cfg_master_en`. The policy's last-requested state after reset is "enabled", and `link_req_valid` is 0 in cycles with no rollover and no cycle start.
- R2: While `cfg_master_en` is 0, `accel_en` is 0 in that same cycle, whatever the flag holds.
- R3: An external strobe (`ctl_req_valid`=1) with `ctl_req_en`=0 sets the flag. An external strobe with `ctl_req_en`=1 clears the flag. The new value shows on `accel_en` from the cycle after the strobe's clock edge.
- R4: `bus_reset` clears the flag at the next edge. It takes priority over any external or policy request in the same cycle.
- R5: `iso_req` clears the flag at the next edge. It has the same priority as `bus_reset`.
- R6: When an external strobe and a policy request arrive in the same cycle, the external strobe sets the flag. The policy still records its own request as its last-requested state.
- R7: A rollover (`cyc_rollover`=1) with no cycle start, in a cycle where the last-requested state is "enabled", drives `link_req_valid`=1 and `link_req_en`=0 in that same cycle. This request disables the speed-ups from the next cycle, unless an external strobe or a restore overrides it.
- R8: A cycle start (`cyc_start_rx`=1), in a cycle where the last-requested state is "disabled", drives `link_req_valid`=1 and `link_req_en`=1 in that same cycle. If a cycle start and a rollover arrive in the same cycle, the cycle start wins and the desired state is "enabled".
- R9: The policy issues no request when its desired state equals its last-requested state.
- R10: In a cycle with `bus_reset` or `iso_req`, the policy issues no request and its last-requested state returns to "enabled".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master_en | input | 1 | Master acceleration enable from configuration |
| bus_reset | input | 1 | Bus reset pulse; restores acceleration |
| iso_req | input | 1 | Isochronous bus request pulse; restores acceleration |
| ctl_req_valid | input | 1 | External acceleration-control strobe |
| ctl_req_en | input | 1 | 1 = enable, 0 = disable, qualified by ctl_req_valid |
| cyc_rollover | input | 1 | Link cycle counter rolled over |
| cyc_start_rx | input | 1 | Link received a cycle start message |
| accel_en | output | 1 | Effective acceleration enable |
| link_req_valid | output | 1 | Policy acceleration-control request strobe |
| link_req_en | output | 1 | Policy request direction (1 = enable) |

## Verification
The master bit reaches `accel_en` in the same cycle. Every change to the flag appears on `accel_en` one cycle after the clock edge that samples its cause. Policy requests appear in the same cycle as the rollover or cycle start that triggers them. The bench drives inputs on the falling edge and compares all three outputs 1 ns later with a behavioural model. The model advances its flag and last-requested state only after that comparison, just as the rising edge does, so each result is checked in the cycle it is due.

// File: rtl/accel_pkg.sv
package accel_pkg;
  typedef struct packed {
    logic valid;
    logic en;
  } acc_req_t;

  localparam logic LAST_REQ_AT_RESET = 1'b1;
  localparam logic FLAG_AT_RESET     = 1'b0;
endpackage

// File: rtl/accel_link_policy.sv
module accel_link_policy
  import accel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restore,
  input  logic     cyc_rollover,
  input  logic     cyc_start_rx,
  output acc_req_t req
);
  logic last_en;
  logic want_en;
  logic event_hit;

  always_comb begin
    event_hit = !restore && (cyc_start_rx || cyc_rollover);
    want_en   = cyc_start_rx;
    req.valid = event_hit && (want_en != last_en);
    req.en    = want_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_en <= LAST_REQ_AT_RESET;
    else if (restore)   last_en <= 1'b1;
    else if (req.valid) last_en <= want_en;
  end
endmodule

// File: rtl/accel_override.sv
module accel_override
  import accel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restore,
  input  acc_req_t ext_req,
  input  acc_req_t pol_req,
  output logic     dis_flag
);
  acc_req_t pick;

  always_comb pick = ext_req.valid ? ext_req : pol_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dis_flag <= FLAG_AT_RESET;
    else if (restore)    dis_flag <= 1'b0;
    else if (pick.valid) dis_flag <= !pick.en;
  end
endmodule

// File: rtl/accel_gate.sv
module accel_gate (
  input  logic master_en,
  input  logic dis_flag,
  output logic eff_en
);
  always_comb eff_en = master_en && !dis_flag;
endmodule

// File: rtl/accel_enable_ctrl.sv
module accel_enable_ctrl
  import accel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master_en,
  input  logic bus_reset,
  input  logic iso_req,
  input  logic ctl_req_valid,
  input  logic ctl_req_en,
  input  logic cyc_rollover,
  input  logic cyc_start_rx,
  output logic accel_en,
  output logic link_req_valid,
  output logic link_req_en
);
  logic     restore;
  logic     dis_flag;
  acc_req_t ext_req;
  acc_req_t pol_req;

  always_comb begin
    restore       = bus_reset || iso_req;
    ext_req.valid = ctl_req_valid;
    ext_req.en    = ctl_req_en;
  end

  accel_link_policy u_policy (
    .clk          (clk),
    .rst_n        (rst_n),
    .restore      (restore),
    .cyc_rollover (cyc_rollover),
    .cyc_start_rx (cyc_start_rx),
    .req          (pol_req)
  );

  accel_override u_override (
    .clk      (clk),
    .rst_n    (rst_n),
    .restore  (restore),
    .ext_req  (ext_req),
    .pol_req  (pol_req),
    .dis_flag (dis_flag)
  );

  accel_gate u_gate (
    .master_en (cfg_master_en),
    .dis_flag  (dis_flag),
    .eff_en    (accel_en)
  );

  always_comb begin
    link_req_valid = pol_req.valid;
    link_req_en    = pol_req.en;
  end
endmodule

// File: rtl/accel_enable_ctrl_chk.sv
module accel_enable_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master_en,
  input logic bus_reset,
  input logic iso_req,
  input logic ctl_req_valid,
  input logic ctl_req_en,
  input logic cyc_rollover,
  input logic cyc_start_rx,
  input logic accel_en,
  input logic link_req_valid,
  input logic link_req_en
);
  p_master_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master_en |-> !accel_en);

  p_ctl_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req_valid && !ctl_req_en && !bus_reset && !iso_req) |=> !accel_en);

  p_ctl_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req_valid && ctl_req_en) |=> (accel_en == cfg_master_en));

  p_bus_reset_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (accel_en == cfg_master_en));

  p_iso_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iso_req |=> (accel_en == cfg_master_en));

  p_rollover_applies_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req_valid && !link_req_en && !ctl_req_valid) |=> !accel_en);

  p_start_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req_valid && cyc_start_rx) |-> link_req_en);

  p_req_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_req_valid |-> (cyc_rollover || cyc_start_rx));

  p_quiet_on_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset || iso_req) |-> !link_req_valid);
endmodule

bind accel_enable_ctrl accel_enable_ctrl_chk u_chk (.*);

// File: tb/accel_enable_ctrl_test.sv
module accel_enable_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master_en = 1'b1;
  logic bus_reset = 1'b0, iso_req = 1'b0;
  logic ctl_req_valid = 1'b0, ctl_req_en = 1'b0;
  logic cyc_rollover = 1'b0, cyc_start_rx = 1'b0;
  logic accel_en, link_req_valid, link_req_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // behavioural reference state
  bit m_flag = 1'b0;
  bit m_last = 1'b1;
  string m_cause = "R1";

  always #4 clk = ~clk;

  accel_enable_ctrl uut (.*);

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit m, input bit br, input bit iso, input bit cv, input bit ce,
                     input bit ro, input bit cs);
    bit rst_cyc, pv, want;
    string ltag;
    @(negedge clk);
    cfg_master_en = m; bus_reset = br; iso_req = iso;
    ctl_req_valid = cv; ctl_req_en = ce; cyc_rollover = ro; cyc_start_rx = cs;
    #1;
    rst_cyc = br || iso;
    want = cs;
    pv = !rst_cyc && (cs || ro) && (want != m_last);
    if (rst_cyc) ltag = "R10";
    else if (cs || ro) ltag = pv ? (cs ? "R8" : "R7") : "R9";
    else ltag = "R1";
    chk(m ? m_cause : "R2", "accel_en", accel_en, m && !m_flag);
    chk(ltag, "link_req_valid", link_req_valid, pv);
    if (pv) chk(ltag, "link_req_en", link_req_en, want);
    // state advance as the rising edge will do
    if (rst_cyc) begin
      m_flag = 1'b0; m_last = 1'b1; m_cause = br ? "R4" : "R5";
    end else begin
      if (cv) begin
        m_flag = !ce; m_cause = pv ? "R6" : "R3";
      end else if (pv) begin
        m_flag = !want; m_cause = want ? "R8" : "R7";
      end
      if (pv) m_last = want;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "accel_en in reset", accel_en, 1'b1);
    rst_n = 1'b1;
    // R1 idle
    repeat (3) cyc(1, 0, 0, 0, 0, 0, 0);
    // R2 master off, flag changes underneath
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R3 enable and disable strobes
    cyc(1, 0, 0, 1, 1, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R4 bus reset restores, and beats a same-cycle disable
    cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R5 iso request restores
    cyc(1, 0, 0, 1, 0, 0, 0);
    cyc(1, 0, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R7 rollover disables, R9 repeat is silent
    cyc(1, 0, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 1, 0);
    // R8 cycle start re-enables, R9 repeat silent
    cyc(1, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 1, 0);
    // R8 start and rollover together: start wins
    cyc(1, 0, 0, 0, 0, 1, 1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R6 external wins over policy disable
    cyc(1, 0, 0, 1, 1, 1, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 1, 0);
    // R10 restore with rollover: no request, last-requested resyncs
    cyc(1, 0, 1, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 8) != 0, ($urandom % 23) == 0, ($urandom % 17) == 0,
          ($urandom % 6) == 0, $urandom % 2, ($urandom % 5) == 0, ($urandom % 5) == 0);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule